// File: doc/BRIEF.md
# Serial Memory Read and Page-Write Sequencer

This block sits behind a serial-bus front end and carries out the two data commands of a byte-wide non-volatile memory: streaming reads and page writes. It owns the byte address counter, a page buffer of `PAGE` bytes with one valid bit per byte, and a single-port internal RAM that stands in for the array. The self-timed programming cycle is modelled by a counter of system clock cycles.

The front end presents a command (read or write plus a 16-bit address) as a one-cycle strobe while the bus select is active. Read data leaves on a valid/ready stream: the sequencer holds `rd_valid_o` with a stable byte until the consumer raises `rd_ready_i`, and only then moves on to the next address. The consumer may hold `rd_ready_i` low for as long as it likes. Write data enters on a valid/ready stream: `wr_ready_o` is high only while a write command is collecting bytes, and the producer may insert idle cycles between bytes. When the select drops, a write either commits or is dropped. The decision uses the write-enable permit, the block-protect level and a flag from the front end that says the deselect came on a byte boundary. A committed page is programmed while `busy_o` is high. When programming ends, a one-cycle pulse tells the protection unit to clear its write-enable latch.

Top module: `rw_page_seq`

## Requirements
- R1: Only the low log2(DEPTH) bits of the 16-bit command address select a byte; the upper bits have no effect.
- R2: A read returns the addressed byte first and then one byte per accepted handshake from each following address. While `rd_valid_o` is high and `rd_ready_i` is low, the byte stays stable.
- R3: A read that passes address DEPTH-1 continues from address 0.
- R4: While `busy_o` is high, a read or write command is ignored: `rd_valid_o` and `wr_ready_o` stay low and no data moves.
- R5: In a write, each accepted byte advances only the low log2(PAGE) address bits. A byte past the page end wraps to the page start, and the last byte received for a page position is the one programmed.
- R6: A write commits only if, at the cycle the select drops, all of the following hold: `desel_aligned_i` is 1, at least one byte was received, `wel_i` is 1, and the page is unprotected. The protect level encoding is: 0 = nothing protected, 1 = top quarter (two address MSBs 11), 2 = top half (MSB 1), 3 = whole array.
- R7: A commit raises `busy_o` in the cycle after the select drop is sampled, and `busy_o` stays high for exactly PROG_CYCLES clock cycles.
- R8: `wel_clr_o` is high for exactly one cycle, in the first cycle after `busy_o` falls.
- R9: Only page positions that received a byte are programmed; other bytes of the page keep their previous contents.
- R10: After reset every array byte reads as FFh, and `busy_o`, `rd_valid_o`, `wr_ready_o` and `wel_clr_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Bus select active (1 = selected) |
| cmd_valid_i | input | 1 | One-cycle command strobe |
| cmd_write_i | input | 1 | 1 = page write, 0 = read |
| cmd_addr_i | input | 16 | Command start address |
| wr_valid_i | input | 1 | Write byte valid |
| wr_data_i | input | 8 | Write byte |
| wr_ready_o | output | 1 | Write byte accepted when high with valid |
| rd_valid_o | output | 1 | Read byte valid |
| rd_data_o | output | 8 | Read byte |
| rd_ready_i | input | 1 | Read byte consumed when high with valid |
| wel_i | input | 1 | Write-enable permit from the protection unit |
| prot_lvl_i | input | 2 | Block-protect level |
| desel_aligned_i | input | 1 | Deselect fell on a byte boundary |
| busy_o | output | 1 | Programming cycle in progress |
| wel_clr_o | output | 1 | One-cycle request to clear the write-enable latch |

## Verification
The embedded assertions check on every cycle that a busy sequencer offers neither read data nor write readiness, and that a stalled read byte holds steady. They also check that the clear pulse follows the fall of busy directly and that programming never starts with an empty valid mask. Only the bench scenarios can show the data-side results. These are the byte sequence across the array top, page wrap with overwrite, the partial-page merge, the exact programming length, and the rejection of each commit condition, which the bench confirms by reading the array back.

// File: rtl/rw_page_seq_pkg.sv
package rw_page_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_FETCH,
    ST_RD_HOLD,
    ST_WR_FILL,
    ST_PROG
  } seq_state_e;

  // Block-protect decode from the two address MSBs.
  function automatic logic prot_hit(input logic [1:0] lvl, input logic [1:0] msbs);
    case (lvl)
      2'd0:    prot_hit = 1'b0;
      2'd1:    prot_hit = (msbs == 2'b11);
      2'd2:    prot_hit = msbs[1];
      default: prot_hit = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/seq_byte_ram.sv
module seq_byte_ram #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [7:0]    wdata,
  input  logic          re,
  output logic [7:0]    rdata
);

  logic [7:0]       mem [DEPTH];
  logic [DEPTH-1:0] written;

  // A per-word written flag gives the erased (FFh) look after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) written <= '0;
    else if (we) written[addr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= written[addr] ? mem[addr] : 8'hFF;
  end

endmodule

// File: rtl/seq_page_buf.sv
module seq_page_buf #(
  parameter int PAGE = 32,
  localparam int OW = $clog2(PAGE)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            wr_en,
  input  logic [OW-1:0]   wr_idx,
  input  logic [7:0]      wr_data,
  input  logic [OW-1:0]   rd_idx,
  output logic [7:0]      rd_data,
  output logic [PAGE-1:0] mask
);

  logic [7:0] bytes [PAGE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask <= '0;
    else if (clr)    mask <= '0;
    else if (wr_en)  mask[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) bytes[wr_idx] <= wr_data;
  end

  assign rd_data = bytes[rd_idx];

endmodule

// File: rtl/rw_page_seq.sv
module rw_page_seq
  import rw_page_seq_pkg::*;
#(
  parameter int DEPTH       = 1024,
  parameter int PAGE        = 32,
  parameter int PROG_CYCLES = 64,
  parameter int CMD_AW      = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int OW = $clog2(PAGE),
  localparam int CW = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              cmd_valid_i,
  input  logic              cmd_write_i,
  input  logic [CMD_AW-1:0] cmd_addr_i,
  input  logic              wr_valid_i,
  input  logic [7:0]        wr_data_i,
  output logic              wr_ready_o,
  output logic              rd_valid_o,
  output logic [7:0]        rd_data_o,
  input  logic              rd_ready_i,
  input  logic              wel_i,
  input  logic [1:0]        prot_lvl_i,
  input  logic              desel_aligned_i,
  output logic              busy_o,
  output logic              wel_clr_o
);

  seq_state_e     state;
  logic [AW-1:0]  addr;
  logic [CW-1:0]  cnt;
  logic           wel_clr_q;

  logic [PAGE-1:0] mask;
  logic [7:0]      buf_rd;
  logic            buf_wr;
  logic            commit_ok;
  logic            in_page;
  logic [AW-1:0]   ram_addr;
  logic            ram_we;
  logic            ram_re;
  logic [7:0]      ram_rdata;

  assign buf_wr    = (state == ST_WR_FILL) && sel_i && wr_valid_i;
  assign commit_ok = desel_aligned_i && (|mask) && wel_i &&
                     !prot_hit(prot_lvl_i, addr[AW-1 -: 2]);
  assign in_page   = cnt < CW'(PAGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      addr      <= '0;
      cnt       <= '0;
      wel_clr_q <= 1'b0;
    end else begin
      wel_clr_q <= 1'b0;
      case (state)
        ST_IDLE: if (sel_i && cmd_valid_i) begin
          addr  <= cmd_addr_i[AW-1:0];
          state <= cmd_write_i ? ST_WR_FILL : ST_RD_FETCH;
        end
        ST_RD_FETCH: state <= sel_i ? ST_RD_HOLD : ST_IDLE;
        ST_RD_HOLD: begin
          if (!sel_i) state <= ST_IDLE;
          else if (rd_ready_i) begin
            addr  <= addr + 1'b1;
            state <= ST_RD_FETCH;
          end
        end
        ST_WR_FILL: begin
          if (!sel_i) begin
            cnt   <= '0;
            state <= commit_ok ? ST_PROG : ST_IDLE;
          end else if (wr_valid_i) begin
            addr[OW-1:0] <= addr[OW-1:0] + 1'b1;
          end
        end
        ST_PROG: begin
          if (cnt == CW'(PROG_CYCLES - 1)) begin
            state     <= ST_IDLE;
            wel_clr_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state == ST_PROG);
  assign rd_valid_o = (state == ST_RD_HOLD);
  assign wr_ready_o = (state == ST_WR_FILL);
  assign wel_clr_o  = wel_clr_q;
  assign rd_data_o  = ram_rdata;

  assign ram_addr = busy_o ? {addr[AW-1:OW], cnt[OW-1:0]} : addr;
  assign ram_we   = busy_o && in_page && mask[cnt[OW-1:0]];
  assign ram_re   = (state == ST_RD_FETCH);

  seq_page_buf #(.PAGE(PAGE)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (state == ST_IDLE),
    .wr_en   (buf_wr),
    .wr_idx  (addr[OW-1:0]),
    .wr_data (wr_data_i),
    .rd_idx  (cnt[OW-1:0]),
    .rd_data (buf_rd),
    .mask    (mask)
  );

  seq_byte_ram #(.DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (ram_addr),
    .we    (ram_we),
    .wdata (buf_rd),
    .re    (ram_re),
    .rdata (ram_rdata)
  );

  AST_BUSY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !rd_valid_o) else $error("read offered while busy"); // R4
  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !wr_ready_o) else $error("write ready while busy"); // R4
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i && sel_i) |=> (rd_valid_o && $stable(rd_data_o)))
    else $error("stalled read byte moved"); // R2
  AST_CLEAR_AFTER_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr_o |-> ($past(busy_o) && !busy_o)) else $error("stray clear pulse"); // R8
  AST_CLEAR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> wel_clr_o) else $error("clear pulse missing"); // R8
  AST_PROG_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (mask != '0)) else $error("programming an empty page"); // R6

endmodule

// File: tb/tb_rw_page_seq.sv
`timescale 1ns/1ps
module tb_rw_page_seq;

  localparam int DEPTH = 1024;
  localparam int PAGE  = 32;
  localparam int PROG  = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [15:0] cmd_addr = '0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        wr_ready, rd_valid, rd_ready = 1'b0;
  logic [7:0]  rd_data;
  logic        wel = 1'b1, aligned = 1'b1;
  logic [1:0]  prot = 2'd0;
  logic        busy, wel_clr;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] model [DEPTH];
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2 clk = ~clk;

  rw_page_seq #(.DEPTH(DEPTH), .PAGE(PAGE), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .cmd_valid_i(cmd_valid),
    .cmd_write_i(cmd_write), .cmd_addr_i(cmd_addr), .wr_valid_i(wr_valid),
    .wr_data_i(wr_data), .wr_ready_o(wr_ready), .rd_valid_o(rd_valid),
    .rd_data_o(rd_data), .rd_ready_i(rd_ready), .wel_i(wel),
    .prot_lvl_i(prot), .desel_aligned_i(aligned), .busy_o(busy),
    .wel_clr_o(wel_clr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares each completed read handshake.
  always @(negedge clk) begin
    #1;
    if (rst_n && rd_valid && rd_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected byte", rd_data, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_data == e, t, rd_data, e);
      end
    end
  end

  task automatic start_cmd(input bit wr, input logic [15:0] a);
    @(negedge clk);
    sel = 1'b1; cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, input int n, input string tag);
    int got = 0;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[(int'(a[9:0]) + i) % DEPTH]);
      tag_q.push_back(tag);
    end
    start_cmd(1'b0, a);
    while (got < n) begin
      @(negedge clk);
      if (rd_valid && got == 1) begin
        rd_ready = 1'b0;           // stall once to exercise hold
        @(negedge clk);
      end
      rd_ready = rd_valid;
      if (rd_valid) got++;
    end
    @(negedge clk);
    rd_ready = 1'b0; sel = 1'b0;
    @(negedge clk);
    chk(exp_q.size() == 0, "R2 all bytes returned", exp_q.size(), 0);
  endtask

  // Sends n bytes (base + 7*i); models the commit when expect_ok.
  task automatic do_write(input logic [15:0] a, input int n, input logic [7:0] base,
                          input bit expect_ok, input string tag);
    logic [9:0] la;
    la = a[9:0];
    start_cmd(1'b1, a);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1'b1; wr_data = base + 8'(7 * i);
      #1;
      chk(wr_ready == 1'b1, "R5 write ready", wr_ready, 1);
      @(negedge clk);
      if (expect_ok)
        model[{la[9:5], 5'(int'(la[4:0]) + i)}] = base + 8'(7 * i);
    end
    wr_valid = 1'b0; sel = 1'b0;
    @(negedge clk);
    chk(busy == expect_ok, tag, busy, expect_ok);
  endtask

  task automatic wait_prog();
    int n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(n == PROG, "R7 busy length", n, PROG);
    chk(wel_clr == 1'b1, "R8 clear pulse", wel_clr, 1);
    @(negedge clk);
    chk(wel_clr == 1'b0, "R8 pulse one cycle", wel_clr, 0);
  endtask

  initial begin
    #(200000 * 4);
    chk(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && rd_valid == 0 && wr_ready == 0 && wel_clr == 0,
        "R10 reset outputs", {busy, rd_valid, wr_ready, wel_clr}, 0);

    do_read(16'h0005, 3, "R10 erased reads FF");

    // Plain page write, high address bits ignored (R1), partial page (R9)
    do_write(16'hFC10, 3, 8'h11, 1'b1, "R7 commit starts busy");
    wait_prog();
    do_read(16'h000E, 8, "R9 partial page merge");
    do_read(16'h8010, 3, "R1 alias address");

    // Page wrap with overwrite
    do_write(16'h005E, 34, 8'h40, 1'b1, "R7 wrap commit");
    wait_prog();
    do_read(16'h0040, 32, "R5 page wrap overwrite");
    do_read(16'h0060, 2, "R5 next page untouched");

    // Commands while busy are ignored
    do_write(16'h0100, 1, 8'hA5, 1'b1, "R7 commit before busy test");
    @(negedge clk);
    sel = 1'b1; cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 16'h0100;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(rd_valid == 0, "R4 read ignored while busy", rd_valid, 0);
    sel = 1'b0;
    @(negedge clk);
    sel = 1'b1; cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 16'h0120;
    @(negedge clk);
    cmd_valid = 1'b0; wr_valid = 1'b1; wr_data = 8'h99;
    @(negedge clk);
    chk(wr_ready == 0, "R4 write ignored while busy", wr_ready, 0);
    wr_valid = 1'b0; sel = 1'b0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    do_read(16'h0120, 1, "R4 no data stored while busy");
    do_read(16'h0100, 1, "R4 busy write committed");

    // Rejections of the commit conditions
    wel = 1'b0;
    do_write(16'h0200, 2, 8'h55, 1'b0, "R6 no permit rejected");
    wel = 1'b1; aligned = 1'b0;
    do_write(16'h0200, 2, 8'h66, 1'b0, "R6 misaligned rejected");
    aligned = 1'b1;
    do_write(16'h0200, 0, 8'h00, 1'b0, "R6 empty write rejected");
    prot = 2'd1;
    do_write(16'h03E0, 1, 8'h77, 1'b0, "R6 top quarter protected");
    prot = 2'd2;
    do_write(16'h0210, 1, 8'h88, 1'b0, "R6 top half protected");
    prot = 2'd3;
    do_write(16'h0000, 1, 8'h12, 1'b0, "R6 whole array protected");
    prot = 2'd1;
    do_write(16'h0200, 1, 8'h3C, 1'b1, "R6 unprotected half accepted");
    wait_prog();
    prot = 2'd0;
    do_read(16'h01FF, 3, "R6 rejected writes left data");
    do_read(16'h03DF, 3, "R6 protected page unchanged");

    // Read wrap across the array top
    do_write(16'h03FE, 4, 8'hC0, 1'b1, "R7 commit at top page");
    wait_prog();
    do_read(16'hA3FD, 6, "R3 read wraps to zero");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule